// File: doc/BRIEF.md
# Power-Off Notification State Controller

This block holds the one-byte power-off notification setting of a managed-flash device and drives the busy indication the host watches on DAT0. The host writes the byte through switch commands. A value of short power-off, long power-off or sleep notification starts a background flush and raises busy. Busy drops when the flush engine reports completion, or when the budget for that code runs out. A running out of budget also sets a sticky timeout flag.

The byte goes back to powered-on in several cases: the host sends a later command, a high-priority interrupt arrives while busy is up, or the device leaves sleep. Illegal writes produce a one-cycle switch-error pulse and leave the byte unchanged. Sleep entry is gated by the byte's state. A refused attempt produces a one-cycle reject pulse.

All outputs are registered. An event sampled at one rising edge is visible on the outputs just after that edge.

Top module: `pwroff_notify_ctrl`

## Requirements
- R1: Codes are 0x00 unsupported, 0x01 powered on, 0x02 short power-off, 0x03 long power-off and 0x04 sleep notification. After reset the code is 0x00 and busy, switch error, sleep, reject and timeout are all low.
- R2: A write of 0x01 while the code is 0x00 or 0x01 sets the code to 0x01 with no busy and no error.
- R3: A write of 0x00 while the code is not 0x00 pulses switch error for one cycle and leaves the code unchanged. A write of 0x00 while the code is 0x00 is accepted silently.
- R4: A write of a value above 0x04, or of 0x02..0x04 while the code is 0x00, pulses switch error with no state change.
- R5: A write of 0x02, 0x03 or 0x04 while the code is 0x01 loads that code and raises busy after the same edge. A flush-done sampled while busy drops busy after that edge and keeps the code.
- R6: Busy lasts at most SHORT_LIMIT, LONG_LIMIT or SLEEP_LIMIT cycles for codes 0x02, 0x03 and 0x04. At the limit busy falls and timeout rises on the same edge. Timeout stays high until reset.
- R7: While the code is 0x02..0x04 and the device is awake, a command or any write returns the code to 0x01 and clears busy. The write's value is not applied and raises no error.
- R8: A high-priority interrupt while busy returns the code to 0x01 and clears busy. A high-priority interrupt with busy low has no effect.
- R9: Sleep entry is accepted only when the code is 0x01, or when it is 0x04 with busy low. Any other attempt pulses reject with no state change.
- R10: While asleep, only sleep exit acts. Exit clears the sleep state and sets the code to 0x01. Commands, interrupts and writes are ignored and raise no error.
- R11: Flush-done while busy is low has no effect.
- R12: When events coincide, the order of precedence is: sleep exit while asleep, then reversion (R7, R8), then sleep entry, then a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Host switch write to the notification byte |
| wr_data_i | input | 8 | Value written |
| cmd_i | input | 1 | Any other host command received |
| hpi_i | input | 1 | High-priority interrupt |
| sleep_enter_i | input | 1 | Sleep entry request |
| sleep_exit_i | input | 1 | Sleep exit request |
| flush_done_i | input | 1 | Background flush completed |
| code_o | output | 8 | Current notification code |
| busy_o | output | 1 | DAT0 busy indication |
| switch_err_o | output | 1 | One-cycle switch error pulse |
| sleep_rej_o | output | 1 | One-cycle refused sleep entry pulse |
| asleep_o | output | 1 | Device in sleep state |
| timeout_o | output | 1 | Sticky busy-budget expiry |

## Verification
The hardest situation to reach from the ports is a busy window that runs out its full budget. Any command, write, interrupt or flush-done during the window cuts it short. Random traffic therefore seldom sees the long-code limit.

Directed steps write each code and then hold all inputs quiet. The bench counts busy cycles against the limit, then checks that a refused sleep entry and a later write still behave correctly with timeout latched. Seeded random traffic with a small overridden budget, compared cycle by cycle against a bench model, covers the remaining interleavings.

// File: rtl/pwroff_pkg.sv
package pwroff_pkg;
  typedef enum logic [7:0] {
    PN_NONE  = 8'h00,
    PN_ON    = 8'h01,
    PN_SHORT = 8'h02,
    PN_LONG  = 8'h03,
    PN_SLEEP = 8'h04
  } pn_code_e;

  localparam logic [7:0] PN_MAX_CODE = 8'h04;

  function automatic logic pn_is_notify(input logic [7:0] c);
    return (c == PN_SHORT) || (c == PN_LONG) || (c == PN_SLEEP);
  endfunction

  function automatic int unsigned pn_max3(input int unsigned a, input int unsigned b,
                                          input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/pn_wr_decode.sv
module pn_wr_decode
  import pwroff_pkg::*;
(
  input  logic [7:0] cur_i,
  input  logic [7:0] data_i,
  output logic       accept_o,
  output logic       start_o,
  output logic       err_o
);
  // only consulted while the current code is 0x00 or 0x01
  always_comb begin
    accept_o = 1'b0;
    start_o  = 1'b0;
    err_o    = 1'b0;
    if (data_i > PN_MAX_CODE) begin
      err_o = 1'b1;
    end else if (data_i == PN_NONE) begin
      if (cur_i != PN_NONE) err_o = 1'b1;
      else accept_o = 1'b1;
    end else if (data_i == PN_ON) begin
      accept_o = 1'b1;
    end else if (cur_i == PN_ON) begin
      accept_o = 1'b1;
      start_o  = 1'b1;
    end else begin
      err_o = 1'b1;
    end
  end
endmodule

// File: rtl/pn_busy_timer.sv
module pn_busy_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [CW-1:0] limit_i,
  output logic          busy_o,
  output logic          expire_o
);
  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic          at_end;

  assign at_end   = (cnt_q == limit_i - CW'(1));
  assign expire_o = busy_q && !start_i && !stop_i && at_end;
  assign busy_o   = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (stop_i || at_end) busy_q <= 1'b0;
      else cnt_q <= cnt_q + CW'(1);
    end
  end

  a_r6_cnt_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q < limit_i));

  a_r6_expire_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !busy_q);
endmodule

// File: rtl/pwroff_notify_ctrl.sv
module pwroff_notify_ctrl
  import pwroff_pkg::*;
#(
  parameter int unsigned SHORT_LIMIT = 64,
  parameter int unsigned LONG_LIMIT  = 1024,
  parameter int unsigned SLEEP_LIMIT = 256
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_valid_i,
  input  logic [7:0] wr_data_i,
  input  logic       cmd_i,
  input  logic       hpi_i,
  input  logic       sleep_enter_i,
  input  logic       sleep_exit_i,
  input  logic       flush_done_i,
  output logic [7:0] code_o,
  output logic       busy_o,
  output logic       switch_err_o,
  output logic       sleep_rej_o,
  output logic       asleep_o,
  output logic       timeout_o
);
  localparam int unsigned MAX_LIM = pn_max3(SHORT_LIMIT, LONG_LIMIT, SLEEP_LIMIT);
  localparam int unsigned CW      = $clog2(MAX_LIM + 1);

  logic [7:0]    code_q, code_d;
  logic          asleep_q, err_q, rej_q, tmo_q;
  logic          busy, expire;
  logic          revert, wake, sleep_ok, sleep_go, sleep_bad, wr_live;
  logic          dec_accept, dec_start, dec_err;
  logic [CW-1:0] limit;

  always_comb begin
    unique case (code_q)
      PN_SHORT: limit = CW'(SHORT_LIMIT);
      PN_LONG:  limit = CW'(LONG_LIMIT);
      default:  limit = CW'(SLEEP_LIMIT);
    endcase
  end

  assign wake      = asleep_q && sleep_exit_i;
  assign revert    = !asleep_q && pn_is_notify(code_q) &&
                     (cmd_i || wr_valid_i || (hpi_i && busy));
  assign sleep_ok  = !asleep_q && !revert && !busy &&
                     ((code_q == PN_ON) || (code_q == PN_SLEEP));
  assign sleep_go  = sleep_enter_i && sleep_ok;
  assign sleep_bad = sleep_enter_i && !asleep_q && !revert && !sleep_ok;
  assign wr_live   = wr_valid_i && !asleep_q && !revert && !sleep_enter_i;

  pn_wr_decode u_dec (
    .cur_i    (code_q),
    .data_i   (wr_data_i),
    .accept_o (dec_accept),
    .start_o  (dec_start),
    .err_o    (dec_err)
  );

  pn_busy_timer #(.CW(CW)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (wr_live && dec_start),
    .stop_i   (revert || flush_done_i),
    .limit_i  (limit),
    .busy_o   (busy),
    .expire_o (expire)
  );

  always_comb begin
    code_d = code_q;
    if (wake || revert)            code_d = PN_ON;
    else if (wr_live && dec_accept) code_d = wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q   <= PN_NONE;
      asleep_q <= 1'b0;
      err_q    <= 1'b0;
      rej_q    <= 1'b0;
      tmo_q    <= 1'b0;
    end else begin
      code_q   <= code_d;
      err_q    <= wr_live && dec_err;
      rej_q    <= sleep_bad;
      if (expire) tmo_q <= 1'b1;
      if (sleep_go)  asleep_q <= 1'b1;
      else if (wake) asleep_q <= 1'b0;
    end
  end

  assign code_o       = code_q;
  assign busy_o       = busy;
  assign switch_err_o = err_q;
  assign sleep_rej_o  = rej_q;
  assign asleep_o     = asleep_q;
  assign timeout_o    = tmo_q;

  a_r5_busy_needs_notify: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> pn_is_notify(code_o));

  a_r3_err_keeps_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    switch_err_o |-> (code_o == $past(code_o)));

  a_r6_timeout_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> timeout_o);

  a_r10_wake_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(asleep_o) |-> (code_o == PN_ON));

  a_r10_no_busy_asleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    asleep_o |-> !busy_o);

  a_r1_code_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_o <= PN_MAX_CODE);

  a_r9_rej_keeps_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_rej_o |-> (asleep_o == $past(asleep_o)));
endmodule

// File: tb/pwroff_notify_ctrl_tb.sv
module pwroff_notify_ctrl_tb_top;
  localparam int unsigned SL = 6;
  localparam int unsigned LL = 14;
  localparam int unsigned PL = 9;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic       cmd = 1'b0, hpi = 1'b0, s_en = 1'b0, s_ex = 1'b0, done = 1'b0;
  logic [7:0] code;
  logic       busy, err, rej, slp, tmo;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pwroff_notify_ctrl #(.SHORT_LIMIT(SL), .LONG_LIMIT(LL), .SLEEP_LIMIT(PL)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wr_valid_i(wr_valid), .wr_data_i(wr_data),
    .cmd_i(cmd), .hpi_i(hpi), .sleep_enter_i(s_en), .sleep_exit_i(s_ex),
    .flush_done_i(done), .code_o(code), .busy_o(busy), .switch_err_o(err),
    .sleep_rej_o(rej), .asleep_o(slp), .timeout_o(tmo)
  );

  // bench model state
  logic [7:0] m_code;
  logic       m_busy, m_err, m_rej, m_slp, m_tmo;
  int         m_cnt;

  function automatic int lim(input logic [7:0] c);
    return (c == 8'h02) ? SL : (c == 8'h03) ? LL : PL;
  endfunction

  task automatic m_reset();
    m_code = 0; m_busy = 0; m_err = 0; m_rej = 0; m_slp = 0; m_tmo = 0; m_cnt = 0;
  endtask

  task automatic m_step(input logic w, input logic [7:0] d, input logic c, input logic h,
                        input logic se, input logic sx, input logic dn);
    logic start, rev;
    start = 0; rev = 0; m_err = 0; m_rej = 0;
    if (m_slp) begin
      if (sx) begin m_slp = 0; m_code = 8'h01; end
    end else if (m_code >= 2 && m_code <= 4 && (c || w || (h && m_busy))) begin
      m_code = 8'h01; m_busy = 0; rev = 1;
    end else if (se) begin
      if (!m_busy && (m_code == 1 || m_code == 4)) m_slp = 1; else m_rej = 1;
    end else if (w) begin
      if (d > 4) m_err = 1;
      else if (d == 0) begin if (m_code != 0) m_err = 1; end
      else if (d == 1) m_code = 8'h01;
      else if (m_code == 1) begin m_code = d; m_busy = 1; m_cnt = 0; start = 1; end
      else m_err = 1;
    end
    if (!start && !rev && m_busy) begin
      if (dn) m_busy = 0;
      else if (m_cnt == lim(m_code) - 1) begin m_busy = 0; m_tmo = 1; end
      else m_cnt++;
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic check(input string tag, input logic [7:0] ec, input logic eb, input logic ee,
                       input logic es, input logic er, input logic et);
    total++;
    if ({code, busy, err, slp, rej, tmo} !== {ec, eb, ee, es, er, et}) begin
      bad++;
      $display("FAIL %s: code=%h busy=%b err=%b slp=%b rej=%b tmo=%b exp %h %b %b %b %b %b",
               tag, code, busy, err, slp, rej, tmo, ec, eb, ee, es, er, et);
    end
  endtask

  // drive one cycle of inputs, sample after the edge at the falling edge
  task automatic cyc(input logic w, input logic [7:0] d, input logic c, input logic h,
                     input logic se, input logic sx, input logic dn);
    wr_valid = w; wr_data = d; cmd = c; hpi = h; s_en = se; s_ex = sx; done = dn;
    @(negedge clk);
    wr_valid = 0; wr_data = 0; cmd = 0; hpi = 0; s_en = 0; s_ex = 0; done = 0;
  endtask

  task automatic wr(input logic [7:0] d); cyc(1, d, 0, 0, 0, 0, 0); endtask
  task automatic idle(); cyc(0, 0, 0, 0, 0, 0, 0); endtask

  task automatic do_reset();
    rst_ni = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
  endtask

  initial begin
    int cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        total++; bad++;
        $display("FAIL watchdog: cycles=%0d exp below 100000", cycles);
        summary();
      end
    end
  end

  initial begin
    int n;
    void'($urandom(32'h51ED));
    do_reset();
    check("R1 reset", 8'h00, 0, 0, 0, 0, 0);

    wr(8'h00); check("R3 zero on zero", 8'h00, 0, 0, 0, 0, 0);
    wr(8'h02); check("R4 notify from zero", 8'h00, 0, 1, 0, 0, 0);
    wr(8'h01); check("R2 power on", 8'h01, 0, 0, 0, 0, 0);
    wr(8'h01); check("R2 power on again", 8'h01, 0, 0, 0, 0, 0);
    wr(8'h00); check("R3 zero after on", 8'h01, 0, 1, 0, 0, 0);
    wr(8'h07); check("R4 out of range", 8'h01, 0, 1, 0, 0, 0);

    wr(8'h02); check("R5 short busy", 8'h02, 1, 0, 0, 0, 0);
    idle(); idle(); check("R5 still busy", 8'h02, 1, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1); check("R5 done drops busy", 8'h02, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1); check("R11 done idle", 8'h02, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 0, 0, 0, 0); check("R7 command reverts", 8'h01, 0, 0, 0, 0, 0);

    wr(8'h03); check("R5 long busy", 8'h03, 1, 0, 0, 0, 0);
    n = 1;
    while (busy && n < 40) begin idle(); if (busy) n++; end
    total++;
    if (n != LL) begin bad++; $display("FAIL R6 busy length: act=%0d exp=%0d", n, LL); end
    check("R6 timeout latched", 8'h03, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 1, 0, 0); check("R9 sleep at long", 8'h03, 0, 0, 0, 1, 1);
    wr(8'h05); check("R7 write reverts", 8'h01, 0, 0, 0, 0, 1);

    wr(8'h04); check("R5 sleep notify busy", 8'h04, 1, 0, 0, 0, 1);
    cyc(0, 0, 0, 1, 0, 0, 0); check("R8 hpi during busy", 8'h01, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 1, 0, 0, 0); check("R8 hpi idle", 8'h01, 0, 0, 0, 0, 1);

    wr(8'h04);
    cyc(0, 0, 0, 0, 1, 0, 0); check("R9 sleep while busy", 8'h04, 1, 0, 0, 1, 1);
    cyc(0, 0, 0, 0, 0, 0, 1); check("R5 notify done", 8'h04, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 1, 0, 0); check("R9 sleep after notify", 8'h04, 0, 0, 1, 0, 1);
    cyc(0, 0, 1, 0, 0, 0, 0); check("R10 cmd ignored", 8'h04, 0, 0, 1, 0, 1);
    wr(8'h00);                check("R10 write ignored", 8'h04, 0, 0, 1, 0, 1);
    cyc(0, 0, 0, 0, 0, 1, 0); check("R10 exit", 8'h01, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 1, 0, 0); check("R9 sleep from on", 8'h01, 0, 0, 1, 0, 1);
    cyc(0, 0, 0, 0, 0, 1, 0); check("R10 exit from on", 8'h01, 0, 0, 0, 0, 1);
    // R12: revert outranks sleep entry and write in the same cycle
    wr(8'h02);
    cyc(1, 8'h09, 0, 0, 1, 0, 0); check("R12 precedence", 8'h01, 0, 0, 0, 0, 1);

    do_reset();
    check("R6 reset clears timeout", 8'h00, 0, 0, 0, 0, 0);

    m_reset();
    for (int i = 0; i < 4000; i++) begin
      logic w, c, h, se, sx, dn;
      logic [7:0] d;
      int r;
      r = $urandom % 16;
      w = (r < 3); c = (r == 3); h = (r == 4); se = (r == 5); sx = (r == 6);
      d = 8'($urandom % 7);
      dn = (($urandom % 12) == 0);
      if (i < 3) begin w = 1; d = 8'h01; end
      m_step(w, d, c, h, se, sx, dn);
      cyc(w, d, c, h, se, sx, dn);
      check("R5,R7,R8,R9,R10,R12 random", m_code, m_busy, m_err, m_slp, m_rej, m_tmo);
    end
    summary();
  end
endmodule